// File: doc/BRIEF.md
# Biphase Line Data Clock Recovery

This block follows the bit-check stage of a low-rate radio receiver. Once bit check has passed, the controller raises `run_i`. The block then times the gap between successive transitions of the debounced data line. It counts the gap in ticks of an extended-clock enable and files each gap as a short (half-bit) interval or a long (full-bit) interval. The long-interval window is not programmed on its own. It is derived from the short-interval limits: its centre is their sum, and its half-width is half their difference, truncated.

The block starts without knowing where the bit boundaries are. It emits no clock until the first long interval appears, because that interval fixes the phase. From then on it tracks whether the last edge sat on the clocking phase and emits one data-clock pulse per bit. Each pulse comes a fixed number of ticks after the edge that qualifies it, together with the decoded bit value. The coding select picks how that bit value is read: the new line level for Manchester, or the long-versus-short pattern for bi-phase.

Any interval that breaks the timing raises a one-cycle error strobe, stops the clock and parks the block. Such an interval is one that fits no window, a long interval that starts off-phase, or a silence longer than the long window. The block stays parked until `run_i` falls, which hands control back to bit check.

Top module: `dclk_recover`

## Requirements
- R1: While `run_i` is low, `dclk_o` and `err_o` stay low and line transitions produce no pulse. After reset, `dclk_o`, `dbit_o` and `err_o` are 0.
- R2: An interval is the number of cycles with `xtick_i` high between two transitions of `data_i`, counting the cycle of the earlier transition. Cycles with `xtick_i` low add nothing.
- R3: An interval is short when `lim_lo_i <= n <= lim_hi_i`, with both ends inclusive.
- R4: An interval is long when `n` lies between (lo+hi) − ⌊(hi−lo)/2⌋ and (lo+hi) + ⌊(hi−lo)/2⌋, with both ends inclusive and the division truncated.
- R5: The limits are captured only while the block is idle (`run_i` low). Changing them during a run does not change how intervals are classified.
- R6: After `run_i` rises, the first transition only starts timing. Short intervals before the first long interval produce no clock. The first long interval locks the phase and produces a pulse.
- R7: Once locked, a long interval from the clocking phase produces a pulse. A pair of short intervals produces a pulse on the second one only.
- R8: A pulse on `dclk_o` rises after the second `xtick_i` following the qualifying edge and stays high for exactly one tick period. With `xtick_i` held high this is 3 cycles after the edge is presented, and the pulse is one cycle wide.
- R9: `dbit_o` is valid while `dclk_o` is high. For `code_sel_i`=0 (Manchester) it equals the line level after the qualifying edge. For `code_sel_i`=1 (bi-phase) it is 0 for a long interval and 1 for a pair of short intervals.
- R10: A timing error raises `err_o` for exactly one cycle and cancels any pending pulse. A timing error is any of these: an interval in neither window, a long interval that starts after a single short one, or a count that exceeds the long upper bound with no transition.
- R11: After an error the block ignores all transitions and emits nothing until `run_i` falls. A new run after that locks normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | High while recovery is enabled (bit check passed) |
| xtick_i | input | 1 | Extended-clock enable; one tick per interval count |
| data_i | input | 1 | Debounced data line |
| lim_lo_i | input | LIM_W | Lower short-interval limit in ticks |
| lim_hi_i | input | LIM_W | Upper short-interval limit in ticks |
| code_sel_i | input | 1 | 0 = Manchester, 1 = bi-phase |
| dclk_o | output | 1 | Recovered data clock, one pulse per bit |
| dbit_o | output | 1 | Decoded bit, valid with `dclk_o` |
| err_o | output | 1 | One-cycle timing-error strobe |

## Verification
The bench builds the block with its default 6-bit limits and a two-tick pulse delay, and holds the tick enable high except in the gating test, so every count equals a cycle count. It uses the limit pair 8/12, whose long window is 18..22. It also uses the pair 9/12, where truncating the half-difference makes 19 fail and 20 pass. A rounding mistake in the window arithmetic therefore shows up at the edges of the long window. Pausing the tick for ten cycles inside a 30-cycle interval separates a count of ticks from a count of cycles.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SYNC,
        ST_LOCK,
        ST_HALT
    } phase_state_e;

    typedef enum logic [1:0] {
        IVL_NONE,
        IVL_HALF,
        IVL_FULL,
        IVL_BAD
    } ivl_kind_e;

    typedef enum logic {
        CODE_MANCH   = 1'b0,
        CODE_BIPHASE = 1'b1
    } line_code_e;

    // One observation of the line per cycle, as seen by the phase tracker.
    typedef struct packed {
        logic      seen;     // transition this cycle
        logic      level;    // line level after the transition
        ivl_kind_e kind;     // class of the interval that just ended
        logic      overrun;  // running count passed the long upper bound
    } ivl_event_t;

    // Long-interval window ends; the half difference truncates toward zero.
    function automatic int full_low(input int lo, input int hi);
        return (lo + hi) - ((hi - lo) / 2);
    endfunction

    function automatic int full_high(input int lo, input int hi);
        return (lo + hi) + ((hi - lo) / 2);
    endfunction

endpackage

// File: rtl/dcr_interval.sv
module dcr_interval #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             data_i,
    output logic             edge_o,
    output logic             level_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic data_q;

    assign edge_o  = data_i ^ data_q;
    assign level_o = data_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= 1'b0;
            count_o <= '0;
        end else begin
            data_q <= data_i;
            if (edge_o) begin
                count_o <= CNT_W'(tick_i);
            end else if (tick_i && count_o != CNT_MAX) begin
                count_o <= count_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcr_window.sv
module dcr_window
    import dcr_pkg::*;
#(
    parameter int LIM_W = 6,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LIM_W-1:0] lim_lo_i,
    input  logic [LIM_W-1:0] lim_hi_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             edge_i,
    output ivl_kind_e        kind_o,
    output logic             overrun_o
);
    localparam int BND_W = LIM_W + 2;

    logic [BND_W-1:0] half_lo_q, half_hi_q, full_lo_q, full_hi_q;
    logic [CNT_W-1:0] half_lo_x, half_hi_x, full_lo_x, full_hi_x;
    logic             in_half, in_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_lo_q <= '0;
            half_hi_q <= '0;
            full_lo_q <= '0;
            full_hi_q <= '0;
        end else if (load_i) begin
            half_lo_q <= BND_W'(lim_lo_i);
            half_hi_q <= BND_W'(lim_hi_i);
            full_lo_q <= BND_W'(full_low(int'(lim_lo_i), int'(lim_hi_i)));
            full_hi_q <= BND_W'(full_high(int'(lim_lo_i), int'(lim_hi_i)));
        end
    end

    assign half_lo_x = CNT_W'(half_lo_q);
    assign half_hi_x = CNT_W'(half_hi_q);
    assign full_lo_x = CNT_W'(full_lo_q);
    assign full_hi_x = CNT_W'(full_hi_q);

    assign in_half   = (count_i >= half_lo_x) && (count_i <= half_hi_x);
    assign in_full   = (count_i >= full_lo_x) && (count_i <= full_hi_x);
    assign overrun_o = count_i > full_hi_x;

    always_comb begin
        if (!edge_i)      kind_o = IVL_NONE;
        else if (in_half) kind_o = IVL_HALF;
        else if (in_full) kind_o = IVL_FULL;
        else              kind_o = IVL_BAD;
    end
endmodule

// File: rtl/dcr_phase.sv
module dcr_phase
    import dcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  line_code_e code_i,
    input  ivl_event_t ev_i,
    output logic       idle_o,
    output logic       fire_o,
    output logic       fire_bit_o,
    output logic       stop_o,
    output logic       err_o
);
    phase_state_e state_q, state_n;
    logic         odd_q, odd_n;
    logic         bad;

    always_comb begin
        state_n    = state_q;
        odd_n      = odd_q;
        fire_o     = 1'b0;
        fire_bit_o = 1'b0;
        bad        = 1'b0;
        unique case (state_q)
            ST_IDLE: if (run_i) state_n = ST_WAIT;
            ST_WAIT: if (ev_i.seen) state_n = ST_SYNC;
            ST_SYNC: begin
                if (ev_i.overrun) begin
                    bad = 1'b1;
                end else if (ev_i.kind == IVL_FULL) begin
                    state_n    = ST_LOCK;
                    odd_n      = 1'b0;
                    fire_o     = 1'b1;
                    fire_bit_o = (code_i == CODE_MANCH) ? ev_i.level : 1'b0;
                end else if (ev_i.kind == IVL_BAD) begin
                    bad = 1'b1;
                end
            end
            ST_LOCK: begin
                if (ev_i.overrun) begin
                    bad = 1'b1;
                end else begin
                    unique case (ev_i.kind)
                        IVL_NONE: ;
                        IVL_HALF: begin
                            odd_n = ~odd_q;
                            if (odd_q) begin
                                fire_o     = 1'b1;
                                fire_bit_o = (code_i == CODE_MANCH) ? ev_i.level : 1'b1;
                            end
                        end
                        IVL_FULL: begin
                            if (odd_q) begin
                                bad = 1'b1;
                            end else begin
                                fire_o     = 1'b1;
                                fire_bit_o = (code_i == CODE_MANCH) ? ev_i.level : 1'b0;
                            end
                        end
                        IVL_BAD: bad = 1'b1;
                    endcase
                end
            end
            ST_HALT: ;
            default: state_n = ST_IDLE;
        endcase
        if (bad) state_n = ST_HALT;
        if (!run_i) begin
            state_n = ST_IDLE;
            fire_o  = 1'b0;
            bad     = 1'b0;
        end
    end

    assign idle_o = (state_q == ST_IDLE);
    assign stop_o = bad || !run_i || (state_q == ST_HALT) || (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            odd_q   <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_n;
            odd_q   <= odd_n;
            err_o   <= bad;
        end
    end
endmodule

// File: rtl/dcr_pulse.sv
module dcr_pulse #(
    parameter int DLY_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic fire_i,
    input  logic bit_i,
    input  logic stop_i,
    output logic dclk_o,
    output logic dbit_o
);
    localparam int DLY_W = $clog2(DLY_TICKS + 1);

    logic [DLY_W-1:0] wait_q;
    logic             held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
            held_q <= 1'b0;
            dclk_o <= 1'b0;
            dbit_o <= 1'b0;
        end else if (stop_i) begin
            wait_q <= '0;
            dclk_o <= 1'b0;
        end else begin
            if (tick_i && dclk_o) dclk_o <= 1'b0;
            if (fire_i) begin
                wait_q <= DLY_W'(DLY_TICKS);
                held_q <= bit_i;
            end else if (tick_i && wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
                if (wait_q == DLY_W'(1)) begin
                    dclk_o <= 1'b1;
                    dbit_o <= held_q;
                end
            end
        end
    end
endmodule

// File: rtl/dclk_recover.sv
module dclk_recover
    import dcr_pkg::*;
#(
    parameter int LIM_W     = 6,
    parameter int DLY_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             xtick_i,
    input  logic             data_i,
    input  logic [LIM_W-1:0] lim_lo_i,
    input  logic [LIM_W-1:0] lim_hi_i,
    input  logic             code_sel_i,
    output logic             dclk_o,
    output logic             dbit_o,
    output logic             err_o
);
    localparam int CNT_W = LIM_W + 3;

    logic             edge_w, level_w, overrun_w, idle_w;
    logic             fire_w, fire_bit_w, stop_w;
    logic [CNT_W-1:0] count_w;
    ivl_kind_e        kind_w;
    ivl_event_t       ev_w;

    dcr_interval #(.CNT_W(CNT_W)) u_interval (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (xtick_i),
        .data_i  (data_i),
        .edge_o  (edge_w),
        .level_o (level_w),
        .count_o (count_w)
    );

    dcr_window #(.LIM_W(LIM_W), .CNT_W(CNT_W)) u_window (
        .clk       (clk),
        .rst       (rst),
        .load_i    (idle_w),
        .lim_lo_i  (lim_lo_i),
        .lim_hi_i  (lim_hi_i),
        .count_i   (count_w),
        .edge_i    (edge_w),
        .kind_o    (kind_w),
        .overrun_o (overrun_w)
    );

    assign ev_w = '{seen: edge_w, level: level_w, kind: kind_w, overrun: overrun_w};

    dcr_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run_i),
        .code_i     (line_code_e'(code_sel_i)),
        .ev_i       (ev_w),
        .idle_o     (idle_w),
        .fire_o     (fire_w),
        .fire_bit_o (fire_bit_w),
        .stop_o     (stop_w),
        .err_o      (err_o)
    );

    dcr_pulse #(.DLY_TICKS(DLY_TICKS)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .tick_i (xtick_i),
        .fire_i (fire_w),
        .bit_i  (fire_bit_w),
        .stop_i (stop_w),
        .dclk_o (dclk_o),
        .dbit_o (dbit_o)
    );
endmodule

// File: rtl/dclk_recover_chk.sv
module dclk_recover_chk (
    input logic clk,
    input logic rst,
    input logic run_i,
    input logic xtick_i,
    input logic dclk_o,
    input logic err_o
);
    logic halted_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) halted_q <= 1'b0;
        else if (err_o)    halted_q <= 1'b1;
    end

    // R1: leaving run quiets both outputs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (!dclk_o && !err_o));

    // R8: a pulse ends at the next tick
    a_r8_one_tick_wide: assert property (@(posedge clk) disable iff (rst)
        (dclk_o && xtick_i) |=> !dclk_o);

    // R8: a pulse holds between ticks unless an error cancels it
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (dclk_o && !xtick_i && run_i) |=> (dclk_o || err_o));

    // R10: error and clock never coincide
    a_r10_err_excl_clk: assert property (@(posedge clk) disable iff (rst)
        !(dclk_o && err_o));

    // R10: the error strobe lasts one cycle
    a_r10_err_single: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    // R11: after an error nothing is emitted until run falls
    a_r11_halt_silent: assert property (@(posedge clk) disable iff (rst)
        halted_q |-> (!dclk_o && !err_o));
endmodule

bind dclk_recover dclk_recover_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run_i),
    .xtick_i (xtick_i),
    .dclk_o  (dclk_o),
    .err_o   (err_o)
);

// File: tb/dclk_recover_bench.sv
module dclk_recover_bench;
    localparam int LIM_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run = 1'b0;
    logic             tick = 1'b1;
    logic             data = 1'b0;
    logic             code = 1'b0;
    logic [LIM_W-1:0] lim_lo = 6'd8;
    logic [LIM_W-1:0] lim_hi = 6'd12;
    logic             dclk, dbit, err;

    int   n_tests = 0, n_fail = 0;
    int   cyc = 0, t_cyc = 0, p_cyc = 0;
    int   pulses = 0, hi_cycles = 0, errs = 0;
    logic p_bit = 1'b0, dclk_d = 1'b0, done = 1'b0;
    logic [15:0] hist = '0;

    dclk_recover #(.LIM_W(LIM_W), .DLY_TICKS(2)) u_dclk_recover (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .xtick_i    (tick),
        .data_i     (data),
        .lim_lo_i   (lim_lo),
        .lim_hi_i   (lim_hi),
        .code_sel_i (code),
        .dclk_o     (dclk),
        .dbit_o     (dbit),
        .err_o      (err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (dclk) begin
            hi_cycles++;
            if (!dclk_d) begin
                pulses++;
                p_cyc = cyc;
                p_bit = dbit;
                hist  = {hist[14:0], dbit};
            end
        end
        dclk_d = dclk;
        if (err) errs++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic toggle(input int k);
        repeat (k) @(negedge clk);
        data  = ~data;
        t_cyc = cyc;
    endtask

    task automatic settle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic begin_run(input int lo, input int hi, input logic c);
        @(negedge clk);
        run    = 1'b0;
        tick   = 1'b1;
        lim_lo = LIM_W'(lo);
        lim_hi = LIM_W'(hi);
        code   = c;
        settle(3);
        run = 1'b1;
    endtask

    task automatic end_run();
        @(negedge clk);
        run = 1'b0;
        settle(3);
    endtask

    task automatic t_reset();
        check("R1 reset dclk", int'(dclk), 0);
        check("R1 reset dbit", int'(dbit), 0);
        check("R1 reset err", int'(err), 0);
    endtask

    task automatic t_idle();
        int p0 = pulses, e0 = errs;
        run = 1'b0;
        toggle(4); toggle(20); toggle(10); toggle(10); toggle(20);
        settle(6);
        check("R1 idle pulses", pulses - p0, 0);
        check("R1 idle errors", errs - e0, 0);
    endtask

    task automatic t_manchester();
        int p0, h0, tc;
        logic e1, e2, e3;
        begin_run(8, 12, 1'b0);
        p0 = pulses; h0 = hi_cycles;
        toggle(5); toggle(10); toggle(10);
        check("R6 no clock before lock", pulses - p0, 0);
        toggle(20); e1 = data; tc = t_cyc;
        toggle(10);
        check("R6 lock pulse", pulses - p0, 1);
        check("R8 delay three cycles", p_cyc - tc, 3);
        check("R9 manchester bit lock", int'(p_bit), int'(e1));
        toggle(10); e2 = data;
        toggle(20); e3 = data;
        check("R7 pulse on second short", pulses - p0, 2);
        check("R9 manchester bit pair", int'(p_bit), int'(e2));
        settle(6);
        check("R7 pulse on long", pulses - p0, 3);
        check("R9 manchester bit long", int'(p_bit), int'(e3));
        check("R8 one cycle wide", hi_cycles - h0, 3);
        end_run();
    endtask

    task automatic t_biphase();
        int p0, e0;
        begin_run(8, 12, 1'b1);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(20); toggle(10); toggle(10); toggle(20);
        settle(6);
        check("R9 biphase pulses", pulses - p0, 3);
        check("R9 biphase bits 010", int'(hist[2:0]), 3'b010);
        check("R9 biphase no error", errs - e0, 0);
        end_run();
    endtask

    task automatic t_short_bounds();
        int p0, e0;
        begin_run(8, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(20); toggle(8); toggle(12);
        settle(5);
        check("R3 limits inclusive pulses", pulses - p0, 2);
        check("R3 limits inclusive no error", errs - e0, 0);
        toggle(2); // interval of 7 after the settle
        settle(4);
        check("R3 below lower limit error", errs - e0, 1);
        end_run();
    endtask

    task automatic t_long_bounds();
        int p0, e0;
        begin_run(8, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(18); toggle(22);
        settle(6);
        check("R4 long window ends pulses", pulses - p0, 2);
        check("R4 long window ends no error", errs - e0, 0);
        end_run();
        begin_run(8, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(17);
        settle(4);
        check("R4 gap between windows error", errs - e0, 1);
        check("R4 gap between windows no pulse", pulses - p0, 0);
        end_run();
    endtask

    task automatic t_truncation();
        int p0, e0;
        begin_run(9, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(20); toggle(22);
        settle(6);
        check("R4 truncated window pulses", pulses - p0, 2);
        check("R4 truncated window no error", errs - e0, 0);
        end_run();
        begin_run(9, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(20); toggle(19);
        settle(4);
        check("R4 truncated lower bound error", errs - e0, 1);
        check("R4 truncated lower bound pulses", pulses - p0, 1);
        end_run();
    endtask

    task automatic t_phase_and_halt();
        int p0, e0;
        begin_run(8, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(20); toggle(10); toggle(20);
        settle(4);
        check("R10 long after single short error", errs - e0, 1);
        p0 = pulses; e0 = errs;
        toggle(20); toggle(10); toggle(10); toggle(20);
        settle(6);
        check("R11 halted no pulses", pulses - p0, 0);
        check("R11 halted no errors", errs - e0, 0);
        end_run();
        begin_run(8, 12, 1'b0);
        p0 = pulses;
        toggle(5); toggle(20);
        settle(6);
        check("R11 relock after run drop", pulses - p0, 1);
        end_run();
    endtask

    task automatic t_timeout();
        int p0, e0;
        begin_run(8, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(20);
        settle(30);
        check("R10 silence timeout error", errs - e0, 1);
        check("R10 timeout keeps lock pulse", pulses - p0, 1);
        end_run();
    endtask

    task automatic t_latch();
        int p0, e0;
        begin_run(8, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5); toggle(20);
        lim_hi = 6'd30;
        toggle(20);
        settle(6);
        check("R5 limits held during run pulses", pulses - p0, 2);
        check("R5 limits held during run no error", errs - e0, 0);
        end_run();
        lim_hi = 6'd12;
    endtask

    task automatic t_tick_gate();
        int p0, e0;
        begin_run(8, 12, 1'b0);
        p0 = pulses; e0 = errs;
        toggle(5);
        tick = 1'b0;
        settle(10);
        tick = 1'b1;
        toggle(20);
        settle(6);
        check("R2 paused ticks not counted pulses", pulses - p0, 1);
        check("R2 paused ticks not counted no error", errs - e0, 0);
        end_run();
    endtask

    initial begin
        settle(3);
        rst = 1'b0;
        settle(1);
        t_reset();
        t_idle();
        t_manchester();
        t_biphase();
        t_short_bounds();
        t_long_bounds();
        t_truncation();
        t_phase_and_halt();
        t_timeout();
        t_latch();
        t_tick_gate();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule